// File: doc/BRIEF.md
# Iterative Radix-2 FFT Core with a Reused Butterfly Stage

This block computes an N-point radix-2 decimation-in-time Fourier transform on complex Q16.16 samples. It builds only one rank of N/2 butterflies. That rank runs log2(N) times, and the data returns to a register bank after each pass. The butterflies stay wired the same way on every pass. A perfect-shuffle pattern between the butterfly outputs and the bank supplies the reordering that a fully unrolled pipeline would hold in its stage-to-stage wiring. Each complex multiply finishes in a single clock cycle, so one pass takes one clock.

Samples enter through an indexed write port while the core is idle. Each sample is placed at the bit-reversed position of its index, so the transform result appears in natural bin order. A start pulse launches the passes. A constant table of N/2 twiddle factors feeds each butterfly, and the table entry used depends on the butterfly number and the pass number. After the last pass the core pulses done, and an indexed read port with no register delay returns the result bins.

Top module: `fft_iter_core`

## Requirements
- R1: Synchronous active-high reset leaves busy and done low and clears every register-bank entry to zero.
- R2: While idle, a write with wr_en high places the sample written at index i into bank position bitrev(i), where the reversal runs over log2(N) bits. Before any transform, reading rd_addr = bitrev(i) returns that sample. For N = 8, index 1 reads back at address 4 and index 3 reads back at address 6.
- R3: After a run, rd_addr = k returns bin X[k] = sum over n of x[n]·e^(-j2πkn/N). X[k] is in natural order, in Q16.16 (value × 65536, two's complement), and lies within a small rounding tolerance.
- R4: A start sampled while idle raises busy on the next edge. The passes then occupy one clock each, and done rises on the log2(N)-th clock edge after the edge that accepted start.
- R5: done is high for exactly one cycle, and busy is low during that cycle.
- R6: A start asserted while busy has no effect. The run ends on schedule, and no second run follows.
- R7: A write asserted while busy has no effect on the bank, so the bins of the running transform are unchanged.
- R8: Once the run is over, the bins stay unchanged and readable at any rd_addr until the next start or write.
- R9: Products return to Q16.16 by truncation, and no per-pass scaling is applied. A constant input of 1.0 on all N samples therefore gives exactly N·65536 in bin 0 and exactly zero in every other bin component.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a transform when idle |
| wr_en | input | 1 | Sample write strobe (idle only) |
| wr_addr | input | log2(N) | Sample index in natural order |
| wr_re | input | 32 | Sample real part, Q16.16 |
| wr_im | input | 32 | Sample imaginary part, Q16.16 |
| rd_addr | input | log2(N) | Bank read index |
| rd_re | output | 32 | Real part at rd_addr |
| rd_im | output | 32 | Imaginary part at rd_addr |
| busy | output | 1 | Passes in progress |
| done | output | 1 | One-cycle pulse after the last pass |

## Verification
The bench builds the core with N = 8, which gives three passes, four butterflies and a four-entry twiddle table. At this size every twiddle entry is reachable, including the ±j and 45-degree values, and the full bit-reversal of the load can be observed. A single-impulse input at sample 1 exercises every twiddle factor directly. A constant input produces bins that can be compared exactly. A mixed complex input checks the rounding against a floating-point DFT computed in the bench. At three passes, the run also leaves a cycle in which a start or write can arrive in the middle of the run.

// File: rtl/fft_pkg.sv
package fft_pkg;

    localparam int DATA_W = 32;
    localparam int FRAC_W = 16;

    typedef logic signed [DATA_W-1:0]   samp_t;
    typedef logic signed [2*DATA_W-1:0] wide_t;

    typedef struct packed {
        samp_t re;
        samp_t im;
    } cplx_t;

    // Full-precision complex product, truncated back to Q16.16
    function automatic cplx_t cmul_q(cplx_t a, cplx_t w);
        wide_t pr;
        wide_t pi;
        cplx_t r;
        pr = wide_t'(a.re) * wide_t'(w.re) - wide_t'(a.im) * wide_t'(w.im);
        pi = wide_t'(a.re) * wide_t'(w.im) + wide_t'(a.im) * wide_t'(w.re);
        r.re = samp_t'(pr >>> FRAC_W);
        r.im = samp_t'(pi >>> FRAC_W);
        return r;
    endfunction

    function automatic cplx_t cadd(cplx_t a, cplx_t b);
        cplx_t r;
        r.re = a.re + b.re;
        r.im = a.im + b.im;
        return r;
    endfunction

    function automatic cplx_t csub(cplx_t a, cplx_t b);
        cplx_t r;
        r.re = a.re - b.re;
        r.im = a.im - b.im;
        return r;
    endfunction

endpackage

// File: rtl/fft_butterfly.sv
module fft_butterfly
    import fft_pkg::*;
(
    input  cplx_t a,
    input  cplx_t b,
    input  cplx_t w,
    output cplx_t sum,
    output cplx_t dif
);

    cplx_t bw;

    always_comb begin
        bw  = cmul_q(b, w);
        sum = cadd(a, bw);
        dif = csub(a, bw);
    end

endmodule

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom
    import fft_pkg::*;
#(
    parameter int N    = 8,
    parameter int LOGN = $clog2(N),
    parameter int PW   = (LOGN > 1) ? $clog2(LOGN) : 1
) (
    input  logic [PW-1:0] pass_idx,
    output cplx_t         tw [N/2]
);

    localparam int  HALF  = N / 2;
    localparam int  IW    = (HALF > 1) ? $clog2(HALF) : 1;
    localparam real TWOPI = 6.283185307179586;
    localparam real SCALE = 2.0 ** FRAC_W;

    cplx_t tab [HALF];

    // W_N^m = cos(2*pi*m/N) - j*sin(2*pi*m/N), quantized to Q16.16
    for (genvar m = 0; m < HALF; m++) begin : g_tab
        localparam real ANG  = TWOPI * real'(m) / real'(N);
        localparam int  C_RE = int'($cos(ANG) * SCALE);
        localparam int  C_IM = int'(-$sin(ANG) * SCALE);
        assign tab[m].re = samp_t'(C_RE);
        assign tab[m].im = samp_t'(C_IM);
    end

    // Butterfly k on pass s uses exponent (k >> (LOGN-1-s)) << (LOGN-1-s)
    always_comb begin
        for (int k = 0; k < HALF; k++) begin
            int sh;
            int ex;
            sh = LOGN - 1 - int'(pass_idx);
            ex = (k >> sh) << sh;
            tw[k] = tab[IW'(ex)];
        end
    end

endmodule

// File: rtl/fft_pass_ctrl.sv
module fft_pass_ctrl #(
    parameter int LOGN = 3,
    parameter int PW   = (LOGN > 1) ? $clog2(LOGN) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic [PW-1:0] pass_idx
);

    localparam logic [PW-1:0] LAST = PW'(LOGN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            pass_idx <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    pass_idx <= '0;
                end
            end else if (pass_idx == LAST) begin
                busy     <= 1'b0;
                done     <= 1'b1;
                pass_idx <= '0;
            end else begin
                pass_idx <= pass_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fft_iter_core.sv
module fft_iter_core
    import fft_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_re,
    input  logic [DATA_W-1:0] wr_im,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_re,
    output logic [DATA_W-1:0] rd_im,
    output logic              busy,
    output logic              done
);

    localparam int LOGN = AW;
    localparam int HALF = N / 2;
    localparam int PW   = (LOGN > 1) ? $clog2(LOGN) : 1;

    cplx_t         bank [N];
    cplx_t         nxt  [N];
    cplx_t         tw   [HALF];
    logic [PW-1:0] pass_idx;
    logic [AW-1:0] wr_rev;

    fft_pass_ctrl #(.LOGN(LOGN), .PW(PW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .busy     (busy),
        .done     (done),
        .pass_idx (pass_idx)
    );

    fft_twiddle_rom #(.N(N), .LOGN(LOGN), .PW(PW)) u_rom (
        .pass_idx (pass_idx),
        .tw       (tw)
    );

    // Fixed rank: butterfly k reads adjacent slots, writes k and k+N/2
    for (genvar k = 0; k < HALF; k++) begin : g_bf
        fft_butterfly u_bf (
            .a   (bank[2*k]),
            .b   (bank[2*k+1]),
            .w   (tw[k]),
            .sum (nxt[k]),
            .dif (nxt[k+HALF])
        );
    end

    always_comb begin
        for (int i = 0; i < AW; i++) begin
            wr_rev[i] = wr_addr[AW-1-i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                bank[i] <= '0;
            end
        end else if (busy) begin
            bank <= nxt;
        end else if (wr_en) begin
            bank[wr_rev] <= '{re: samp_t'(wr_re), im: samp_t'(wr_im)};
        end
    end

    assign rd_re = bank[rd_addr].re;
    assign rd_im = bank[rd_addr].im;

endmodule

// File: rtl/fft_iter_core_chk.sv
module fft_iter_core_chk #(
    parameter int N    = 8,
    parameter int LOGN = $clog2(N),
    parameter int PW   = (LOGN > 1) ? $clog2(LOGN) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [PW-1:0] pass_idx
);

    localparam logic [PW-1:0] LAST = PW'(LOGN - 1);

    assert_start_accept_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && pass_idx == '0));

    assert_done_at_end_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_pass_advance_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && pass_idx != LAST) |=> (busy && pass_idx == $past(pass_idx) + 1'b1));

    assert_run_stops_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && pass_idx == LAST) |=> !busy);

endmodule

bind fft_iter_core fft_iter_core_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .pass_idx (pass_idx)
);

// File: tb/sim_fft_iter_core.sv
module sim_fft_iter_core;

    localparam int N     = 8;
    localparam int AW    = 3;
    localparam int NCASE = 4;
    localparam int TOL   = 64;

    // Stimulus in units of 1/256 (256 = 1.0)
    localparam int STIM_RE [NCASE*N] = '{
        256, 0, 0, 0, 0, 0, 0, 0,
        256, 256, 256, 256, 256, 256, 256, 256,
        0, 256, 0, 0, 0, 0, 0, 0,
        100, -50, 200, 30, -120, 60, 10, -80
    };
    localparam int STIM_IM [NCASE*N] = '{
        0, 0, 0, 0, 0, 0, 0, 0,
        0, 0, 0, 0, 0, 0, 0, 0,
        0, 0, 0, 0, 0, 0, 0, 0,
        20, 0, -40, 90, 5, -70, 33, 12
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_re = '0;
    logic [31:0]   wr_im = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_re;
    logic [31:0]   rd_im;
    logic          busy;
    logic          done;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    fft_iter_core #(.N(N)) u0 (
        .clk(clk), .rst(rst), .start(start), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_re(wr_re), .wr_im(wr_im),
        .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_sample(input int idx, input int re, input int im);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(idx);
        wr_re   = 32'(re);
        wr_im   = 32'(im);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic load_case(input int c);
        for (int n = 0; n < N; n++) begin
            write_sample(n, STIM_RE[c*N+n] * 256, STIM_IM[c*N+n] * 256);
        end
    endtask

    // Start a run; optionally inject a start and a write mid-run
    task automatic run_fft(input bit mid_start, input bit mid_write);
        int k;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R4 busy after start", longint'(busy), 1);
        k = 0;
        while (!done && k < 20) begin
            if (k == 1 && mid_start) start = 1'b1;
            if (k == 1 && mid_write) begin
                wr_en = 1'b1; wr_addr = '0;
                wr_re = 32'h7fff_0000; wr_im = 32'h1234_0000;
            end
            @(posedge clk);
            k++;
            @(negedge clk);
            start = 1'b0;
            wr_en = 1'b0;
        end
        chk(k == AW, "R4 done latency", k, AW);
        chk(done && !busy, "R5 done with busy low", longint'({done, busy}), 2);
        @(negedge clk);
        chk(!done, "R5 done one cycle", longint'(done), 0);
        if (mid_start) chk(!busy, "R6 no restart", longint'(busy), 0);
    endtask

    task automatic check_bins(input int c, input string req);
        for (int k = 0; k < N; k++) begin
            real er, ei;
            longint xr, xi, ar, ai;
            er = 0.0; ei = 0.0;
            for (int n = 0; n < N; n++) begin
                real th, sr, si;
                th = 6.283185307179586 * real'(k * n) / real'(N);
                sr = real'(STIM_RE[c*N+n]) / 256.0;
                si = real'(STIM_IM[c*N+n]) / 256.0;
                er = er + sr * $cos(th) + si * $sin(th);
                ei = ei + si * $cos(th) - sr * $sin(th);
            end
            xr = longint'(er * 65536.0);
            xi = longint'(ei * 65536.0);
            rd_addr = AW'(k);
            #1;
            ar = longint'($signed(rd_re));
            ai = longint'($signed(rd_im));
            chk((ar - xr <= TOL) && (xr - ar <= TOL), req, ar, xr);
            chk((ai - xi <= TOL) && (xi - ai <= TOL), req, ai, xi);
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy, "R1 busy", longint'(busy), 0);
        chk(!done, "R1 done", longint'(done), 0);
        rd_addr = 3'd5; #1;
        chk(rd_re == 0 && rd_im == 0, "R1 bank cleared", longint'(rd_re), 0);

        // R2: bit-reversed placement on load
        write_sample(1, 32'h0001_0000, 32'h0000_0200);
        write_sample(3, 32'h0002_0000, 32'hffff_0000);
        rd_addr = 3'd4; #1;
        chk(rd_re == 32'h0001_0000 && rd_im == 32'h0000_0200, "R2 idx1->addr4", longint'(rd_re), 65536);
        rd_addr = 3'd6; #1;
        chk(rd_re == 32'h0002_0000 && rd_im == 32'hffff_0000, "R2 idx3->addr6", longint'(rd_re), 131072);

        // R3: table walk over all stimulus vectors
        for (int c = 0; c < NCASE; c++) begin
            load_case(c);
            run_fft(1'b0, 1'b0);
            check_bins(c, "R3 bin");
        end

        // R8: bins held after idle cycles and address changes
        repeat (10) @(negedge clk);
        rd_addr = 3'd7;
        @(negedge clk);
        check_bins(3, "R8 bins held");

        // R9: exact result for a constant input
        load_case(1);
        run_fft(1'b0, 1'b0);
        for (int k = 0; k < N; k++) begin
            rd_addr = AW'(k); #1;
            chk($signed(rd_re) == ((k == 0) ? N * 65536 : 0) && rd_im == 0,
                "R9 exact constant bin", longint'($signed(rd_re)), (k == 0) ? N * 65536 : 0);
        end

        // R6: start during a run is ignored
        load_case(2);
        run_fft(1'b1, 1'b0);
        check_bins(2, "R6 bins after mid-run start");

        // R7: write during a run is ignored
        load_case(3);
        run_fft(1'b0, 1'b1);
        check_bins(3, "R7 bins after mid-run write");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule